// File: doc/BRIEF.md
# Authenticated-Encryption Phase Control Register

This block holds the phase selector and the valid-byte count that steer a Galois/Counter authenticated-encryption engine. Software writes one 32-bit word carrying both fields. The block cleans up illegal encodings before it uses them. A value is only taken after software writes the same word twice in a row. When the two writes differ, the block raises a recoverable alert. Any read resets this double-write tracking.

Updates are accepted only while the engine reports idle and no storage fault is latched. A phase change that is not one of the allowed successors of the current phase is refused and flagged. A second copy of the stored value is kept bitwise inverted. If the two copies ever disagree, or if the external fault input is raised, a sticky storage-error flag is set and only reset clears it.

A three-state machine tracks the double-write sequence:
- EMPTY: no first write is held. An accepted write moves to PENDING.
- PENDING: a first write is held. A read while in PENDING returns to EMPTY, unless a write arrives in the same cycle. In that case the write becomes the new first write and the state stays PENDING. An accepted second write returns to EMPTY; it commits, is refused or raises the alert.
- LOCKED: entered from any state once the storage error is latched. It is left only by reset.

Top module: `gcm_phase_ctrl`

## Requirements
- R1: After reset the phase is INIT and the byte count is 16. The read word is 0x0000_1001, and the strobe, alert, sequence and storage-error outputs are low.
- R2: The phase field is bits 6:0 of the write word and is one-hot: INIT=0000001, RESTORE=0000010, AAD=0000100, TEXT=0001000, SAVE=0010000, LEN=0100000, TAG=1000000. A value that is zero or has more than one bit set is treated as INIT.
- R3: The byte count is bits 12:8 of the write word. A written 0 is treated as 16; other values are kept.
- R4: A value is stored only after two consecutive accepted writes with equal cleaned values. A single write leaves the outputs unchanged.
- R5: If the second write differs from the first, the alert pulses for one cycle and the stored value is kept. The next write then starts a new sequence.
- R6: A read clears the held first write, so the next write is a first write. A write in the same cycle as a read counts as a first write.
- R7: Writes made while the engine is not idle are ignored and do not disturb a held first write.
- R8: The legal successors are:
  - INIT: RESTORE, AAD, TEXT
  - RESTORE: INIT, AAD, TEXT
  - AAD: INIT, TEXT, SAVE, LEN
  - TEXT: INIT, SAVE, LEN
  - SAVE: INIT
  - LEN: INIT, TAG
  - TAG: INIT

  Rewriting the current phase is always legal. A matched pair that asks for any other change keeps the old value and pulses the sequence-error flag for one cycle.
- R9: Each commit pulses the update strobe for one cycle.
- R10: The storage-error flag sets when the fault input is high or the inverted copy disagrees with the stored value. It then stays set until reset and blocks all later writes.
- R11: The read word is the byte count at bits 12:8 and the phase at bits 6:0, with all other bits zero.
- R12: With the enable parameter cleared, the phase is always INIT and the byte count is always 16, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Register read data |
| engine_idle_i | input | 1 | Engine idle status |
| fault_i | input | 1 | External storage-fault indication |
| phase_o | output | 7 | Committed phase, one-hot |
| nbytes_o | output | 5 | Committed valid-byte count |
| upd_strobe_o | output | 1 | One-cycle pulse on commit |
| upd_alert_o | output | 1 | One-cycle recoverable mismatch alert |
| bad_seq_o | output | 1 | One-cycle illegal-transition flag |
| store_err_o | output | 1 | Sticky storage-error flag |

## Verification
The bench walks all 49 ordered pairs of phases. Each pair is reached through a legal path, so a wrong entry in the successor table shows up as a wrong phase or a missing or extra sequence pulse. It writes all 128 raw phase codes and all 32 byte counts to two instances, one with the enable parameter set and one with it cleared. A wrong sanitizing rule or a leak from the disabled instance then appears as wrong read data.

Three sequencing cases are aimed at the tracking logic:
- A read between two equal writes. A design that ignored the read would commit early.
- A mismatched pair followed by a single write. A design that kept the first write would commit too soon.
- Writes while the engine is busy. A design that did not gate them would change the value or the held first write.

The sticky storage fault is checked by trying to commit after the fault pulse has ended.

// File: rtl/gcm_phase_pkg.sv
package gcm_phase_pkg;
    localparam int PH_W = 7;
    localparam int NB_W = 5;

    localparam logic [PH_W-1:0] PH_INIT    = 7'b0000001;
    localparam logic [PH_W-1:0] PH_RESTORE = 7'b0000010;
    localparam logic [PH_W-1:0] PH_AAD     = 7'b0000100;
    localparam logic [PH_W-1:0] PH_TEXT    = 7'b0001000;
    localparam logic [PH_W-1:0] PH_SAVE    = 7'b0010000;
    localparam logic [PH_W-1:0] PH_LEN     = 7'b0100000;
    localparam logic [PH_W-1:0] PH_TAG     = 7'b1000000;

    localparam logic [NB_W-1:0] NB_FULL = 5'd16;

    typedef struct packed {
        logic [NB_W-1:0] nbytes;
        logic [PH_W-1:0] phase;
    } gcm_cfg_t;

    typedef enum logic [1:0] {
        SH_EMPTY   = 2'd0,
        SH_PENDING = 2'd1,
        SH_LOCKED  = 2'd2
    } sh_state_e;
endpackage

// File: rtl/gcm_phase_sanitize.sv
module gcm_phase_sanitize
    import gcm_phase_pkg::*;
#(
    parameter bit GCM_EN = 1'b1
) (
    input  logic [PH_W-1:0] raw_phase_i,
    input  logic [NB_W-1:0] raw_nbytes_i,
    output gcm_cfg_t        clean_o
);
    generate
        if (GCM_EN) begin : g_on
            always_comb begin
                clean_o.phase  = ($countones(raw_phase_i) == 1) ? raw_phase_i : PH_INIT;
                clean_o.nbytes = (raw_nbytes_i == '0) ? NB_FULL : raw_nbytes_i;
            end
        end else begin : g_off
            logic unused_raw;
            assign unused_raw = ^{raw_phase_i, raw_nbytes_i};
            always_comb begin
                clean_o.phase  = PH_INIT;
                clean_o.nbytes = NB_FULL;
            end
        end
    endgenerate

    always_comb begin
        assert_clean_onehot_R2: assert ($countones(clean_o.phase) == 1);
    end
endmodule

// File: rtl/gcm_phase_seq_check.sv
module gcm_phase_seq_check
    import gcm_phase_pkg::*;
(
    input  logic [PH_W-1:0] cur_i,
    input  logic [PH_W-1:0] nxt_i,
    output logic            legal_o
);
    logic [PH_W-1:0] allowed;

    always_comb begin
        unique case (cur_i)
            PH_INIT:    allowed = PH_RESTORE | PH_AAD | PH_TEXT;
            PH_RESTORE: allowed = PH_INIT | PH_AAD | PH_TEXT;
            PH_AAD:     allowed = PH_INIT | PH_TEXT | PH_SAVE | PH_LEN;
            PH_TEXT:    allowed = PH_INIT | PH_SAVE | PH_LEN;
            PH_SAVE:    allowed = PH_INIT;
            PH_LEN:     allowed = PH_INIT | PH_TAG;
            PH_TAG:     allowed = PH_INIT;
            default:    allowed = PH_INIT;
        endcase
        legal_o = (nxt_i == cur_i) || ((allowed & nxt_i) != '0);
    end
endmodule

// File: rtl/gcm_phase_shadow.sv
module gcm_phase_shadow
    import gcm_phase_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wr_en_i,
    input  logic     rd_en_i,
    input  logic     idle_i,
    input  logic     fault_i,
    input  logic     legal_i,
    input  gcm_cfg_t wr_val_i,
    output gcm_cfg_t cfg_o,
    output logic     strobe_o,
    output logic     alert_o,
    output logic     bad_seq_o,
    output logic     err_o
);
    localparam gcm_cfg_t CFG_RST = '{nbytes: NB_FULL, phase: PH_INIT};

    sh_state_e st_q, st_d;
    gcm_cfg_t  pend_q, pend_d, prim_q, prim_d, inv_q;
    logic      strobe_q, strobe_d, alert_q, alert_d, bad_q, bad_d, err_q, err_d;
    logic      wr_go, copy_bad;

    assign wr_go    = wr_en_i && idle_i;
    assign copy_bad = (prim_q != ~inv_q);

    // next state and datapath
    always_comb begin
        st_d     = st_q;
        pend_d   = pend_q;
        prim_d   = prim_q;
        strobe_d = 1'b0;
        alert_d  = 1'b0;
        bad_d    = 1'b0;
        err_d    = err_q || fault_i || copy_bad;
        unique case (st_q)
            SH_EMPTY: begin
                if (wr_go) begin
                    pend_d = wr_val_i;
                    st_d   = SH_PENDING;
                end
            end
            SH_PENDING: begin
                if (rd_en_i) begin
                    if (wr_go) pend_d = wr_val_i;
                    else       st_d   = SH_EMPTY;
                end else if (wr_go) begin
                    st_d = SH_EMPTY;
                    if (wr_val_i != pend_q) begin
                        alert_d = 1'b1;
                    end else if (!legal_i) begin
                        bad_d = 1'b1;
                    end else begin
                        prim_d   = wr_val_i;
                        strobe_d = 1'b1;
                    end
                end
            end
            SH_LOCKED: begin
                st_d = SH_LOCKED;
            end
            default: st_d = SH_LOCKED;
        endcase
        if (err_d) st_d = SH_LOCKED;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= SH_EMPTY;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
        end
    end

    // data and pulse registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q   <= CFG_RST;
            prim_q   <= CFG_RST;
            inv_q    <= ~CFG_RST;
            strobe_q <= 1'b0;
            alert_q  <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            pend_q   <= pend_d;
            prim_q   <= prim_d;
            inv_q    <= ~prim_d;
            strobe_q <= strobe_d;
            alert_q  <= alert_d;
            bad_q    <= bad_d;
        end
    end

    assign cfg_o     = prim_q;
    assign strobe_o  = strobe_q;
    assign alert_o   = alert_q;
    assign bad_seq_o = bad_q;
    assign err_o     = err_q;

    assert_alert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_q |=> !alert_q);
    assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_q |=> !strobe_q);
    assert_bad_seq_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_q |=> !bad_q);
    assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_q |=> err_q);
    assert_locked_with_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_q |-> st_q == SH_LOCKED);
    assert_locked_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_q |=> $stable(prim_q));
    assert_pulses_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({strobe_q, alert_q, bad_q}));
endmodule

// File: rtl/gcm_phase_ctrl.sv
module gcm_phase_ctrl
    import gcm_phase_pkg::*;
#(
    parameter bit GCM_EN = 1'b1,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              engine_idle_i,
    input  logic              fault_i,
    output logic [PH_W-1:0]   phase_o,
    output logic [NB_W-1:0]   nbytes_o,
    output logic              upd_strobe_o,
    output logic              upd_alert_o,
    output logic              bad_seq_o,
    output logic              store_err_o
);
    localparam int NB_LSB = 8;
    localparam int PAD_W  = DATA_W - NB_LSB - NB_W;

    gcm_cfg_t clean_val, cfg_now;
    logic     legal;

    logic unused_wdata;
    assign unused_wdata = ^{wr_data_i[DATA_W-1:NB_LSB+NB_W], wr_data_i[NB_LSB-1:PH_W]};

    gcm_phase_sanitize #(.GCM_EN(GCM_EN)) u_sanitize (
        .raw_phase_i  (wr_data_i[PH_W-1:0]),
        .raw_nbytes_i (wr_data_i[NB_LSB+NB_W-1:NB_LSB]),
        .clean_o      (clean_val)
    );

    gcm_phase_seq_check u_seq (
        .cur_i   (cfg_now.phase),
        .nxt_i   (clean_val.phase),
        .legal_o (legal)
    );

    gcm_phase_shadow u_shadow (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .idle_i    (engine_idle_i),
        .fault_i   (fault_i),
        .legal_i   (legal),
        .wr_val_i  (clean_val),
        .cfg_o     (cfg_now),
        .strobe_o  (upd_strobe_o),
        .alert_o   (upd_alert_o),
        .bad_seq_o (bad_seq_o),
        .err_o     (store_err_o)
    );

    assign phase_o   = cfg_now.phase;
    assign nbytes_o  = cfg_now.nbytes;
    assign rd_data_o = {{PAD_W{1'b0}}, cfg_now.nbytes, {(NB_LSB-PH_W){1'b0}}, cfg_now.phase};

    assert_phase_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(phase_o));
    assert_nbytes_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nbytes_o != '0);
    assert_busy_no_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !engine_idle_i |=> $stable(rd_data_o));
    assert_change_needs_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rd_data_o) |-> upd_strobe_o);
endmodule

// File: tb/gcm_phase_ctrl_tb.sv
module gcm_phase_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        idle = 1'b1;
    logic        fault = 1'b0;
    logic [31:0] rd_data, rd_data_off;
    logic [6:0]  phase, phase_off;
    logic [4:0]  nbytes, nbytes_off;
    logic        strobe, alert, bad, err;
    logic        strobe_off, alert_off, bad_off, err_off;

    int total = 0;
    int bad_cnt = 0;
    bit done = 0;
    logic s_strobe, s_alert, s_bad;

    always #2.5 clk = ~clk;

    gcm_phase_ctrl #(.GCM_EN(1'b1)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_data_o(rd_data), .engine_idle_i(idle), .fault_i(fault),
        .phase_o(phase), .nbytes_o(nbytes), .upd_strobe_o(strobe),
        .upd_alert_o(alert), .bad_seq_o(bad), .store_err_o(err)
    );

    gcm_phase_ctrl #(.GCM_EN(1'b0)) u_dut_off (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_data_o(rd_data_off), .engine_idle_i(idle), .fault_i(fault),
        .phase_o(phase_off), .nbytes_o(nbytes_off), .upd_strobe_o(strobe_off),
        .upd_alert_o(alert_off), .bad_seq_o(bad_off), .store_err_o(err_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ph(input int i);
        return 7'(1 << i);
    endfunction

    // successor rule for one-hot indices 0..6 (INIT..TAG)
    function automatic bit legal_idx(input int c, input int n);
        if (c == n) return 1;
        case (c)
            0: return n inside {1, 2, 3};
            1: return n inside {0, 2, 3};
            2: return n inside {0, 3, 4, 5};
            3: return n inside {0, 4, 5};
            4: return n == 0;
            5: return n inside {0, 6};
            default: return n == 0;
        endcase
    endfunction

    function automatic int idx_of(input logic [6:0] p);
        for (int i = 0; i < 7; i++) if (p == ph(i)) return i;
        return 0;
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        s_strobe = strobe; s_alert = alert; s_bad = bad;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pair(input int p, input int nb);
        wr({19'b0, 5'(nb), 1'b0, ph(p)});
        wr({19'b0, 5'(nb), 1'b0, ph(p)});
    endtask

    task automatic reach(input int p);
        pair(0, 16);
        case (p)
            4: begin pair(2, 16); pair(4, 16); end
            5: begin pair(3, 16); pair(5, 16); end
            6: begin pair(3, 16); pair(5, 16); pair(6, 16); end
            default: if (p != 0) pair(p, 16);
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad_cnt++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad_cnt);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 phase", 32'(phase), 32'h01);
        chk("R1 nbytes", 32'(nbytes), 32'd16);
        chk("R1 rdata", rd_data, 32'h0000_1001);
        chk("R1 pulses", {29'b0, strobe, alert, bad}, 32'h0);
        chk("R1 err", 32'(err), 32'h0);

        // R4 single write does not commit; R9 strobe on commit; R11 layout
        wr(32'h0000_0508);
        chk("R4 single write", 32'(phase), 32'h01);
        chk("R4 no strobe", 32'(s_strobe), 32'h0);
        wr(32'h0000_0508);
        chk("R4 commit", 32'(phase), 32'h08);
        chk("R9 strobe", 32'(s_strobe), 32'h1);
        chk("R11 rdata", rd_data, 32'h0000_0508);
        @(negedge clk);
        chk("R9 strobe one cycle", 32'(strobe), 32'h0);

        // R5 mismatch alert
        wr(32'h0000_1020);
        wr(32'h0000_1010);
        chk("R5 alert", 32'(s_alert), 32'h1);
        chk("R5 value kept", rd_data, 32'h0000_0508);
        @(negedge clk);
        chk("R5 alert one cycle", 32'(alert), 32'h0);
        wr(32'h0000_1010);
        chk("R5 new sequence", rd_data, 32'h0000_0508);
        wr(32'h0000_1010);
        chk("R5 then commit", rd_data, 32'h0000_1010);

        // R6 read clears pending
        pair(0, 16);
        wr(32'h0000_0704);
        rd();
        wr(32'h0000_0704);
        chk("R6 read cleared", rd_data, 32'h0000_1001);
        chk("R6 no strobe", 32'(s_strobe), 32'h0);
        wr(32'h0000_0704);
        chk("R6 commit after", rd_data, 32'h0000_0704);

        // R6 write in same cycle as read counts as first
        pair(0, 16);
        wr(32'h0000_0302);
        @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0402;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        chk("R6 same-cycle no commit", rd_data, 32'h0000_1001);
        wr(32'h0000_0402);
        chk("R6 same-cycle first", rd_data, 32'h0000_0402);

        // R7 busy writes ignored
        pair(0, 16);
        wr(32'h0000_0902);
        idle = 1'b0;
        wr(32'h0000_0A04);
        wr(32'h0000_0A04);
        chk("R7 busy ignored", rd_data, 32'h0000_1001);
        idle = 1'b1;
        wr(32'h0000_0902);
        chk("R7 pending kept", rd_data, 32'h0000_0902);

        // R8 full successor table
        for (int c = 0; c < 7; c++) begin
            for (int n = 0; n < 7; n++) begin
                bit lg;
                reach(c);
                lg = legal_idx(c, n);
                pair(n, 16);
                chk($sformatf("R8 %0d->%0d phase", c, n), 32'(phase), 32'(lg ? ph(n) : ph(c)));
                chk($sformatf("R8 %0d->%0d bad", c, n), 32'(s_bad), 32'(!lg));
                chk($sformatf("R9 %0d->%0d strobe", c, n), 32'(s_strobe), 32'(lg));
            end
        end

        // R2 and R12 phase sanitize sweep
        for (int v = 0; v < 128; v++) begin
            logic [6:0] e;
            pair(0, 16);
            e = ($countones(7'(v)) == 1) ? 7'(v) : 7'h01;
            wr({19'b0, 5'd16, 1'b0, 7'(v)});
            wr({19'b0, 5'd16, 1'b0, 7'(v)});
            chk($sformatf("R2 raw %0d", v), 32'(phase),
                32'(legal_idx(0, idx_of(e)) ? e : 7'h01));
            chk($sformatf("R12 raw %0d", v), rd_data_off, 32'h0000_1001);
        end

        // R3 and R12 byte-count sweep
        pair(0, 16);
        for (int v = 0; v < 32; v++) begin
            wr({19'b0, 5'(v), 8'hFF});
            wr({19'b0, 5'(v), 8'hFF});
            chk($sformatf("R3 nb %0d", v), rd_data, 32'((v == 0 ? 16 : v) << 8) | 32'h01);
            chk($sformatf("R12 nb %0d", v), rd_data_off, 32'h0000_1001);
        end

        // R10 sticky storage error
        pair(0, 16);
        @(negedge clk); fault = 1'b1;
        @(negedge clk); fault = 1'b0;
        chk("R10 err set", 32'(err), 32'h1);
        repeat (4) @(negedge clk);
        chk("R10 err sticky", 32'(err), 32'h1);
        pair(3, 8);
        chk("R10 write blocked", rd_data, 32'h0000_1001);
        chk("R10 no strobe", 32'(s_strobe), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad_cnt);
        $finish;
    end
endmodule